// File: doc/BRIEF.md
# Power-Good Qualification Channel

This block is one channel of a multi-rail supply supervisor. It receives a digital "rail above threshold" bit from an analog comparator, an active-high channel enable and a global undervoltage-lockout flag. From these it produces a power-good output. The output rises only after the rail has been continuously qualified for a programmable number of clock cycles. It falls within a few cycles when qualification is lost.

The rail and enable inputs are asynchronous, so each passes through a two-flop synchronizer. The enable then goes through a run-length glitch filter. The qualification delay comes from a configuration word. When that word is zero, a fixed default count is used instead. The lockout flag is a synchronous chip-level signal, and it forces the output low in the same cycle it is asserted. Channels can be daisy-chained by wiring one channel's power-good output to the next channel's enable, which sequences the rails one after another.

Top module: `pg_channel`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `pg_o` and `pg_seen_o` are both 0.
- R2: With the filtered enable high and lockout clear, a rail bit held at 1 makes `pg_o` rise at the (D+2)-th rising edge after the change. D is `cfg_delay_i` when it is nonzero.
- R3: When `cfg_delay_i` is 0, D is the parameter `DFLT_RISE` (8750 cycles by default, which is 35 µs at 250 MHz).
- R4: If qualification drops before D cycles have been counted, `pg_o` stays low and counting restarts from zero. The next rise again needs a full D cycles of continuous qualification.
- R5: A rail bit falling to 0 makes `pg_o` go low at the 3rd rising edge after the change, with no qualification wait.
- R6: An enable falling to 0 and staying low makes `pg_o` go low at the (GLITCH_LEN+3)-th rising edge after the change.
- R7: An enable pulse, high or low, that lasts fewer than `GLITCH_LEN` cycles (70 by default) has no effect on `pg_o`.
- R8: While `uvlo_i` is 1, `pg_o` is 0 in that same cycle, whatever the rail and enable are. The delay count is cleared. After `uvlo_i` returns to 0 with the rail and enable still qualified, `pg_o` rises at the D-th edge.
- R9: `pg_seen_o` goes to 1 at the edge after `pg_o` is first seen high. It is cleared at any edge where `uvlo_i` is 1, and otherwise it holds its value.
- R10: Once `pg_o` has been high, the delay count is held at zero. After a later fall, the next rise again takes exactly D+2 edges from the rail change.
- R11: In a daisy chain (the upstream `pg_o` drives the downstream `en_i`), the downstream output rises GLITCH_LEN+D+2 edges after the upstream output rises, and it follows the upstream output down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uvlo_i | input | 1 | Global undervoltage lockout, synchronous, active high |
| rail_ok_i | input | 1 | Comparator bit, 1 = rail above threshold (asynchronous) |
| en_i | input | 1 | Channel enable, active high (asynchronous) |
| cfg_delay_i | input | 16 | Rise qualification delay in cycles; 0 selects the default |
| pg_o | output | 1 | Power-good output |
| pg_seen_o | output | 1 | Sticky flag: output has been high since lockout last cleared |

## Verification
The bench runs two channels in a daisy chain and compares both outputs against a behavioural model on every clock. The stimulus includes clean rail rises and falls, which separate the exact rise latency from the immediate fall. Rail pulses shorter than the delay show whether the counter restarts or merely pauses. Enable glitches shorter than the filter window and enable drops longer than it show whether the filter threshold sits exactly at the run length. A lockout pulse taken while the output is high shows that the output is forced low combinationally and that the sticky flag is cleared. Switching the configuration word to zero exercises the default delay path.

// File: rtl/pg_pkg.sv
// Package: shared widths and default timing constants for the power-good channel.
// Assumes a 250 MHz clock when turning the default times into cycle counts.
package pg_pkg;
    localparam int unsigned PG_CNT_W      = 16;
    localparam int unsigned PG_DFLT_RISE  = 8750; // 35 us at 250 MHz
    localparam int unsigned PG_GLITCH_LEN = 70;   // 280 ns at 250 MHz
    localparam int unsigned PG_SYNC_STAGES = 2;
    typedef logic [PG_CNT_W-1:0] pg_cnt_t;
endpackage

// File: rtl/pg_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes the inputs are quasi-static levels; pulses are not captured.
module pg_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pg_en_filter.sv
// Module: run-length glitch filter. The filtered level follows the input only
// after the input has differed from it for GLITCH_LEN consecutive cycles.
// Assumes a synchronized input.
module pg_en_filter #(
    parameter int unsigned GLITCH_LEN = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s_i,
    output logic en_f_o
);
    localparam int unsigned GW = $clog2(GLITCH_LEN + 1);

    logic          en_f_q;
    logic [GW-1:0] run_q;

    // Count consecutive disagreeing cycles and flip once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_f_q <= 1'b0;
            run_q  <= '0;
        end else if (en_s_i == en_f_q) begin
            run_q  <= '0;
        end else if (run_q == GW'(GLITCH_LEN - 1)) begin
            en_f_q <= en_s_i;
            run_q  <= '0;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign en_f_o = en_f_q;

    // R7: the filtered level may change only at the end of a full run.
    a_r7_flip_after_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        (en_f_q != $past(en_f_q)) |-> ($past(run_q) == GW'(GLITCH_LEN - 1)));
endmodule

// File: rtl/pg_rise_timer.sv
// Module: restartable rise-qualification timer. It raises the good flag after
// the qualification input has been continuously true for the delay count, and
// drops the flag at once when qualification is lost.
// Assumes a delay count of at least 1.
module pg_rise_timer
    import pg_pkg::*;
#(
    parameter int unsigned DFLT_RISE = PG_DFLT_RISE
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    qual_i,
    input  pg_cnt_t cfg_delay_i,
    output logic    good_o
);
    pg_cnt_t need;
    pg_cnt_t tcnt_q;
    logic    good_q;

    // Choose the configured delay, or the default when the word is zero.
    always_comb begin
        need = (cfg_delay_i == '0) ? pg_cnt_t'(DFLT_RISE) : cfg_delay_i;
    end

    // Count qualified cycles; clear on loss or once the flag is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= 1'b0;
            tcnt_q <= '0;
        end else if (!qual_i) begin
            good_q <= 1'b0;
            tcnt_q <= '0;
        end else if (good_q) begin
            tcnt_q <= '0;
        end else if (tcnt_q >= need - 1'b1) begin
            good_q <= 1'b1;
            tcnt_q <= '0;
        end else begin
            tcnt_q <= tcnt_q + 1'b1;
        end
    end

    assign good_o = good_q;

    // R10: the counter sits at zero while the flag is high.
    a_r10_count_idle_when_good: assert property (@(posedge clk) disable iff (!rst_n)
        good_q |-> (tcnt_q == '0));
    // R4: a lost qualification leaves the counter at zero.
    a_r4_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_i |=> (tcnt_q == '0));
    // R2: a rise happens only after a completed count under qualification.
    a_r2_rise_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(good_q) |-> ($past(qual_i) && ($past(tcnt_q) >= $past(need) - 1'b1)));
endmodule

// File: rtl/pg_channel.sv
// Module: one power-good channel of a multi-rail supervisor. It synchronizes
// the rail and enable bits, filters the enable, qualifies the rise with a
// restartable delay and forces the output low under lockout.
// Assumes uvlo_i is already synchronous to clk.
module pg_channel
    import pg_pkg::*;
#(
    parameter int unsigned DFLT_RISE   = PG_DFLT_RISE,
    parameter int unsigned GLITCH_LEN  = PG_GLITCH_LEN,
    parameter int unsigned SYNC_STAGES = PG_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                uvlo_i,
    input  logic                rail_ok_i,
    input  logic                en_i,
    input  logic [PG_CNT_W-1:0] cfg_delay_i,
    output logic                pg_o,
    output logic                pg_seen_o
);
    logic [1:0] raw_in;
    logic [1:0] sync_out;
    logic       rail_s;
    logic       en_s;
    logic       en_f;
    logic       qual;
    logic       good;
    logic       seen_q;

    assign raw_in = {en_i, rail_ok_i};

    pg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign rail_s = sync_out[0];
    assign en_s   = sync_out[1];

    pg_en_filter #(.GLITCH_LEN(GLITCH_LEN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_s_i (en_s),
        .en_f_o (en_f)
    );

    // Qualification: rail up, filtered enable up, no lockout.
    always_comb begin
        qual = rail_s && en_f && !uvlo_i;
    end

    pg_rise_timer #(.DFLT_RISE(DFLT_RISE)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .qual_i      (qual),
        .cfg_delay_i (cfg_delay_i),
        .good_o      (good)
    );

    // Output gating: lockout overrides the registered flag in the same cycle.
    always_comb begin
        pg_o = good && !uvlo_i;
    end

    // Sticky flag: set by a high output, cleared by lockout.
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (uvlo_i) seen_q <= 1'b0;
        else if (pg_o)   seen_q <= 1'b1;
    end

    assign pg_seen_o = seen_q;

    // R8: lockout leaves the timer flag low at the next edge.
    a_r8_lockout_clears_timer: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> !good);
    // R9: a high output is recorded by the sticky flag.
    a_r9_seen_records_good: assert property (@(posedge clk) disable iff (!rst_n)
        pg_o |=> pg_seen_o);
    // R5: a rail bit seen low drops the output at the following edge.
    a_r5_rail_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_s |=> !pg_o);
endmodule

// File: tb/pg_channel_bench.sv
module pg_channel_bench;
    localparam int DFLT = 8750;
    localparam int GL   = 70;
    localparam int D0   = 5;
    localparam int D1   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uvlo = 1'b1;
    logic        rail0 = 1'b0, rail1 = 1'b0, en0 = 1'b0;
    logic [15:0] cfg0 = 16'(D0), cfg1 = 16'(D1);
    logic        pg0, pg1, seen0, seen1;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk; // 250 MHz

    pg_channel u_pg_channel (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .rail_ok_i(rail0), .en_i(en0),
        .cfg_delay_i(cfg0), .pg_o(pg0), .pg_seen_o(seen0));

    pg_channel u_pg_channel_nxt (
        .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .rail_ok_i(rail1), .en_i(pg0),
        .cfg_delay_i(cfg1), .pg_o(pg1), .pg_seen_o(seen1));

    // Behavioural reference: input histories, run lengths and a qualified-cycle count.
    logic m_r1[2], m_r2[2], m_e1[2], m_e2[2], m_ef[2], m_pg[2], m_seen[2];
    int   m_run[2], m_tc[2];

    always @(posedge clk) begin : model
        logic up_out, raw_en, raw_rail, q;
        int need;
        up_out = m_pg[0] && !uvlo;
        for (int k = 0; k < 2; k++) begin
            raw_en   = (k == 0) ? en0 : up_out;
            raw_rail = (k == 0) ? rail0 : rail1;
            need     = (k == 0) ? ((cfg0 == 0) ? DFLT : int'(cfg0))
                                : ((cfg1 == 0) ? DFLT : int'(cfg1));
            if (!rst_n) begin
                m_r1[k] = 0; m_r2[k] = 0; m_e1[k] = 0; m_e2[k] = 0;
                m_ef[k] = 0; m_pg[k] = 0; m_seen[k] = 0; m_run[k] = 0; m_tc[k] = 0;
            end else begin
                q = m_r2[k] && m_ef[k] && !uvlo;
                m_seen[k] = !uvlo && (m_seen[k] || (m_pg[k] && !uvlo));
                if (!q) begin m_pg[k] = 0; m_tc[k] = 0; end
                else if (m_pg[k]) m_tc[k] = 0;
                else if (m_tc[k] >= need - 1) begin m_pg[k] = 1; m_tc[k] = 0; end
                else m_tc[k]++;
                if (m_e2[k] == m_ef[k]) m_run[k] = 0;
                else if (m_run[k] == GL - 1) begin m_ef[k] = m_e2[k]; m_run[k] = 0; end
                else m_run[k]++;
                m_r2[k] = m_r1[k]; m_r1[k] = raw_rail;
                m_e2[k] = m_e1[k]; m_e1[k] = raw_en;
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison with the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(pg0,   m_pg[0] && !uvlo, cur_req, "pg0");
            check(pg1,   m_pg[1] && !uvlo, cur_req, "pg1");
            check(seen0, m_seen[0],        cur_req, "seen0");
            check(seen1, m_seen[1],        cur_req, "seen1");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Count negedges until a signal reaches a level (drive happens just before).
    task automatic wait_level(ref logic sig, input logic lvl, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig !== lvl && n < lim);
        #1;
    endtask

    initial begin : wd
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        int n;
        cyc(4);
        rst_n = 1'b1;
        #0;
        check(pg0, 1'b0, "R1", "pg0 after reset");
        check(seen0, 1'b0, "R1", "seen0 after reset");
        check(pg1, 1'b0, "R1", "pg1 after reset");

        cur_req = "R2";
        uvlo = 1'b0; en0 = 1'b1; rail1 = 1'b1;
        cyc(100);
        rail0 = 1'b1;
        wait_level(pg0, 1'b1, 50, n);
        check_int(n, D0 + 2, "R2", "rise latency");
        cur_req = "R11";
        wait_level(pg1, 1'b1, 200, n);
        check_int(n, GL + D1 + 2, "R11", "chained rise latency");
        cyc(10);

        cur_req = "R5";
        rail0 = 1'b0;
        wait_level(pg0, 1'b0, 50, n);
        check_int(n, 3, "R5", "fall latency");
        cur_req = "R11";
        wait_level(pg1, 1'b0, 200, n);
        check(pg1, 1'b0, "R11", "chained fall");
        cyc(100);

        cur_req = "R4";
        rail0 = 1'b1; cyc(3); rail0 = 1'b0; cyc(2); rail0 = 1'b1; cyc(1); rail0 = 1'b0; cyc(4);
        check(pg0, 1'b0, "R4", "short qualification stays low");
        rail0 = 1'b1;
        wait_level(pg0, 1'b1, 50, n);
        check_int(n, D0 + 2, "R4", "full delay after restart");
        cyc(120);

        cur_req = "R10";
        rail0 = 1'b0; cyc(6);
        rail0 = 1'b1;
        wait_level(pg0, 1'b1, 50, n);
        check_int(n, D0 + 2, "R10", "re-rise takes full delay");
        cyc(120);

        cur_req = "R7";
        en0 = 1'b0; cyc(GL - 10); en0 = 1'b1;
        cyc(150);
        check(pg0, 1'b1, "R7", "short enable drop ignored");
        check(pg1, 1'b1, "R7", "downstream unaffected");

        cur_req = "R6";
        en0 = 1'b0;
        wait_level(pg0, 1'b0, 200, n);
        check_int(n, GL + 3, "R6", "enable fall latency");
        cyc(20);
        en0 = 1'b1; cyc(GL - 10); en0 = 1'b0; cyc(100);
        check(pg0, 1'b0, "R7", "short enable pulse ignored");
        en0 = 1'b1;
        cyc(200);
        check(pg1, 1'b1, "R11", "chain back up");

        cur_req = "R8";
        check(seen0, 1'b1, "R9", "seen set before lockout");
        uvlo = 1'b1;
        @(negedge clk);
        check(pg0, 1'b0, "R8", "lockout same cycle");
        check(pg1, 1'b0, "R8", "lockout downstream");
        #1;
        cyc(3);
        check(seen0, 1'b0, "R9", "seen cleared by lockout");
        uvlo = 1'b0;
        wait_level(pg0, 1'b1, 50, n);
        check_int(n, D0, "R8", "rise after lockout release");
        cur_req = "R9";
        cyc(2);
        check(seen0, 1'b1, "R9", "seen set again");
        cyc(200);

        cur_req = "R3";
        rail0 = 1'b0; cyc(10);
        cfg0 = 16'd0;
        cyc(2);
        rail0 = 1'b1;
        wait_level(pg0, 1'b1, DFLT + 100, n);
        check_int(n, DFLT + 2, "R3", "default rise latency");
        cyc(200);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule